// File: doc/BRIEF.md
# Internal Data Memory Unit for an 8-bit Core

This block is the on-chip data store of a small 8-bit microcontroller core. It holds 256 bytes of RAM and a 128-entry special-register window. It resolves every byte access by the addressing mode the core supplies. One address value can land in different storage. A direct access above 0x7F goes to a special register. An indirect access at the same value goes to the upper half of RAM. A bank-register access names one of eight working registers in one of four banks.

A second port works on single bits. The 256-entry bit space covers sixteen RAM bytes in its lower half and the special registers whose address is a multiple of eight in its upper half. A bit can be read, set, cleared or written with a value. The update is a read-modify-write of the containing byte, done in one cycle. The bank used for register references is a two-bit field inside a status special register. Software changes it by writing that register through either port.

Top module: `imem_unit`

## Requirements
- R1: A direct access (acc_mode 0) with address 0x00–0x7F reads and writes RAM byte at that address, the same byte an indirect access with that address reaches.
- R2: A direct access with address 0x80–0xFF reads and writes special register (address − 0x80) and never touches RAM.
- R3: An indirect access (acc_mode 1) reads and writes RAM byte at the full 8-bit address, including 0x80–0xFF, and never touches a special register.
- R4: A bank-register access (acc_mode 2) uses acc_addr[2:0] as register number n and reaches RAM byte bank*8+n. The bank is bits [4:3] of the special register at direct address 0xD0. With bank 3, register 4 is byte 0x1C.
- R5: A bank-register access never reaches a special register, including the accumulator at direct address 0xE0.
- R6: Bit addresses 0x00–0x7F select bit (addr mod 8) of RAM byte 0x20 + addr/8; bit_rdata shows it.
- R7: Bit addresses 0x80–0xFF select bit (addr mod 8) of the special register at direct address (addr AND 0xF8).
- R8: bit_op encodes 0 none, 1 set, 2 clear, 3 write bit_wval. The selected bit changes at the next rising edge and the other seven bits of its byte keep their value.
- R9: When a byte write and a bit operation hit the same byte in one cycle, the byte write's data is stored. When they hit different bytes, both take effect.
- R10: Byte and bit reads reflect the stored state in the same cycle. Writes become visible after the next rising clock edge.
- R11: A synchronous active-high reset clears all RAM and all special registers, so the bank returns to 0.
- R12: acc_mode 3 is reserved: acc_rdata reads 0 and a write with it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | Byte addressing mode: 0 direct, 1 indirect, 2 bank register, 3 reserved |
| acc_addr | input | 8 | Byte address, or register number in bits [2:0] |
| acc_we | input | 1 | Byte write enable |
| acc_wdata | input | 8 | Byte write data |
| acc_rdata | output | 8 | Byte read data, combinational |
| bit_addr | input | 8 | Bit-space address |
| bit_op | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 write |
| bit_wval | input | 1 | Value stored by bit operation 3 |
| bit_rdata | output | 1 | Current value of the addressed bit, combinational |

## Verification
Both read outputs are combinational, so a result is due in the same cycle as its address. A write is due one rising edge after the cycle that carries it. The bench changes inputs on the falling edge and samples reads 1 ns later, before the next rising edge. It checks a write only at the following falling edge, one edge after the write. For the same-cycle visibility rule, the bench samples the old value just before the edge and the new one just after it. A bench-side model of both arrays and the bank field gives every expected byte and bit.

// File: rtl/imem_pkg.sv
package imem_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_BANKREG  = 2'd2,
    AM_RSVD     = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_PUT  = 2'd3
  } bop_e;

  // resolved byte target
  typedef struct packed {
    logic       valid;
    logic       to_sfr;
    logic [7:0] idx;
  } byte_tgt_t;

  // resolved bit target
  typedef struct packed {
    logic       to_sfr;
    logic [7:0] idx;
    logic [2:0] pos;
  } bit_tgt_t;
endpackage

// File: rtl/imem_byte_resolve.sv
module imem_byte_resolve
  import imem_pkg::*;
(
  input  amode_e     mode,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  output byte_tgt_t  tgt
);
  always_comb begin
    tgt = '0;
    unique case (mode)
      AM_DIRECT: begin
        tgt.valid  = 1'b1;
        tgt.to_sfr = addr[7];
        tgt.idx    = addr[7] ? {1'b0, addr[6:0]} : addr;
      end
      AM_INDIRECT: begin
        tgt.valid = 1'b1;
        tgt.idx   = addr;
      end
      AM_BANKREG: begin
        tgt.valid = 1'b1;
        tgt.idx   = {3'b000, bank, addr[2:0]};
      end
      default: tgt = '0;
    endcase
  end
endmodule

// File: rtl/imem_bit_resolve.sv
module imem_bit_resolve
  import imem_pkg::*;
#(
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic [7:0] baddr,
  output bit_tgt_t   tgt
);
  always_comb begin
    tgt.pos    = baddr[2:0];
    tgt.to_sfr = baddr[7];
    if (baddr[7]) tgt.idx = {1'b0, baddr[6:3], 3'b000};
    else          tgt.idx = BIT_BASE + {4'b0000, baddr[6:3]};
  end
endmodule

// File: rtl/imem_regfile.sv
module imem_regfile #(
  parameter int DEPTH   = 256,
  parameter int DW      = 8,
  parameter int TAP_IDX = 0,
  parameter int TAP_LSB = 0,
  parameter int TAP_W   = 1,
  localparam int IW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    ra_idx,
  output logic [DW-1:0]    ra_q,
  input  logic [IW-1:0]    rb_idx,
  output logic [DW-1:0]    rb_q,
  input  logic             wa_en,
  input  logic [IW-1:0]    wa_idx,
  input  logic [DW-1:0]    wa_d,
  input  logic             wb_en,
  input  logic [IW-1:0]    wb_idx,
  input  logic [DW-1:0]    wb_d,
  output logic [TAP_W-1:0] tap_q
);
  logic [DW-1:0] mem [DEPTH];

  assign ra_q  = mem[ra_idx];
  assign rb_q  = mem[rb_idx];
  assign tap_q = mem[TAP_IDX][TAP_LSB +: TAP_W];

  // port A (byte path) wins over port B (bit path) on the same entry
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wb_en && !(wa_en && (wa_idx == wb_idx))) mem[wb_idx] <= wb_d;
      if (wa_en) mem[wa_idx] <= wa_d;
    end
  end

  // R9
  porta_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> mem[$past(wa_idx)] == $past(wa_d));

  // R9
  portb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !(wa_en && wa_idx == wb_idx)) |=> mem[$past(wb_idx)] == $past(wb_d));
endmodule

// File: rtl/imem_unit.sv
module imem_unit
  import imem_pkg::*;
#(
  parameter logic [7:0] STATUS_ADDR = 8'hD0,
  parameter int         BANK_LSB    = 3,
  parameter logic [7:0] BIT_BASE    = 8'h20,
  parameter int         RAM_DEPTH   = 256,
  parameter int         SFR_DEPTH   = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] acc_mode,
  input  logic [7:0] acc_addr,
  input  logic       acc_we,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic [7:0] bit_addr,
  input  logic [1:0] bit_op,
  input  logic       bit_wval,
  output logic       bit_rdata
);
  localparam int RAM_IW     = $clog2(RAM_DEPTH);
  localparam int SFR_IW     = $clog2(SFR_DEPTH);
  localparam int STATUS_IDX = int'(STATUS_ADDR[6:0]);

  logic [1:0] bank;
  byte_tgt_t  bt;
  bit_tgt_t   kt;
  amode_e     mode;
  bop_e       bop;
  logic [7:0] ram_ra_q, ram_rb_q, sfr_ra_q, sfr_rb_q;
  logic [7:0] kbyte, kbyte_nx;
  logic       ram_wa_en, sfr_wa_en, ram_wb_en, sfr_wb_en;

  assign mode = amode_e'(acc_mode);
  assign bop  = bop_e'(bit_op);

  imem_byte_resolve u_bres (.mode(mode), .addr(acc_addr), .bank(bank), .tgt(bt));
  imem_bit_resolve #(.BIT_BASE(BIT_BASE)) u_kres (.baddr(bit_addr), .tgt(kt));

  assign ram_wa_en = acc_we && bt.valid && !bt.to_sfr;
  assign sfr_wa_en = acc_we && bt.valid &&  bt.to_sfr;
  assign ram_wb_en = (bop != BOP_NONE) && !kt.to_sfr;
  assign sfr_wb_en = (bop != BOP_NONE) &&  kt.to_sfr;

  imem_regfile #(.DEPTH(RAM_DEPTH), .DW(8), .TAP_IDX(0), .TAP_LSB(0), .TAP_W(8)) u_ram (
    .clk(clk), .rst(rst),
    .ra_idx(bt.idx[RAM_IW-1:0]), .ra_q(ram_ra_q),
    .rb_idx(kt.idx[RAM_IW-1:0]), .rb_q(ram_rb_q),
    .wa_en(ram_wa_en), .wa_idx(bt.idx[RAM_IW-1:0]), .wa_d(acc_wdata),
    .wb_en(ram_wb_en), .wb_idx(kt.idx[RAM_IW-1:0]), .wb_d(kbyte_nx),
    .tap_q()
  );

  imem_regfile #(.DEPTH(SFR_DEPTH), .DW(8), .TAP_IDX(STATUS_IDX),
                 .TAP_LSB(BANK_LSB), .TAP_W(2)) u_sfr (
    .clk(clk), .rst(rst),
    .ra_idx(bt.idx[SFR_IW-1:0]), .ra_q(sfr_ra_q),
    .rb_idx(kt.idx[SFR_IW-1:0]), .rb_q(sfr_rb_q),
    .wa_en(sfr_wa_en), .wa_idx(bt.idx[SFR_IW-1:0]), .wa_d(acc_wdata),
    .wb_en(sfr_wb_en), .wb_idx(kt.idx[SFR_IW-1:0]), .wb_d(kbyte_nx),
    .tap_q(bank)
  );

  always_comb begin
    if (!bt.valid)     acc_rdata = 8'h00;
    else if (bt.to_sfr) acc_rdata = sfr_ra_q;
    else               acc_rdata = ram_ra_q;
  end

  assign kbyte     = kt.to_sfr ? sfr_rb_q : ram_rb_q;
  assign bit_rdata = kbyte[kt.pos];

  always_comb begin
    kbyte_nx = kbyte;
    unique case (bop)
      BOP_SET: kbyte_nx[kt.pos] = 1'b1;
      BOP_CLR: kbyte_nx[kt.pos] = 1'b0;
      BOP_PUT: kbyte_nx[kt.pos] = bit_wval;
      default: kbyte_nx = kbyte;
    endcase
  end

  // R3
  indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'd1) |-> (!sfr_wa_en && !bt.to_sfr));

  // R4
  bank_follows_status_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_we && acc_mode == 2'd0 && acc_addr == STATUS_ADDR)
      |=> bank == $past(acc_wdata[BANK_LSB +: 2]));

  // R5
  bankreg_low_only_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'd2) |-> (!bt.to_sfr && bt.idx < 8'd32));

  // R6
  bit_low_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_addr[7]) |-> (!kt.to_sfr && kt.idx >= BIT_BASE && kt.idx < BIT_BASE + 8'd16));

  // R12
  reserved_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'd3) |-> (acc_rdata == 8'h00 && !ram_wa_en && !sfr_wa_en));
endmodule

// File: tb/tb_imem_unit.sv
`timescale 1ns/1ps
module tb_imem_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] acc_mode = 2'd0;
  logic [7:0] acc_addr = 8'h00;
  logic       acc_we = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic [7:0] bit_addr = 8'h00;
  logic [1:0] bit_op = 2'd0;
  logic       bit_wval = 1'b0;
  logic       bit_rdata;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [128];

  always #2 clk = ~clk;

  imem_unit dut (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .acc_addr(acc_addr), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .bit_addr(bit_addr), .bit_op(bit_op),
    .bit_wval(bit_wval), .bit_rdata(bit_rdata)
  );

  function automatic logic [1:0] bank_m();
    return sfr_m[7'h50][4:3];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] m, input logic [7:0] a);
    case (m)
      2'd0: return a[7] ? sfr_m[a[6:0]] : ram_m[a];
      2'd1: return ram_m[a];
      2'd2: return ram_m[8 * bank_m() + a[2:0]];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bit_byte_addr(input logic [7:0] a);
    return a[7] ? (a & 8'hF8) : (8'h20 + a / 8);
  endfunction

  function automatic logic [7:0] read_direct_m(input logic [7:0] d);
    return d[7] ? sfr_m[d[6:0]] : ram_m[d];
  endfunction

  task automatic write_direct_m(input logic [7:0] d, input logic [7:0] v);
    if (d[7]) sfr_m[d[6:0]] = v;
    else      ram_m[d] = v;
  endtask

  task automatic mdl_byte_wr(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d);
    case (m)
      2'd0: write_direct_m(a, d);
      2'd1: ram_m[a] = d;
      2'd2: ram_m[8 * bank_m() + a[2:0]] = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] bit_next(input logic [7:0] a, input logic [1:0] op, input logic v);
    logic [7:0] b;
    b = read_direct_m(bit_byte_addr(a));
    case (op)
      2'd1: b[a % 8] = 1'b1;
      2'd2: b[a % 8] = 1'b0;
      2'd3: b[a % 8] = v;
      default: ;
    endcase
    return b;
  endfunction

  task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr_byte(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d);
    acc_mode = m; acc_addr = a; acc_wdata = d; acc_we = 1'b1;
    mdl_byte_wr(m, a, d);
    @(posedge clk); @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] m, input logic [7:0] a, input string req);
    acc_mode = m; acc_addr = a; acc_we = 1'b0;
    #1;
    check8(req, acc_rdata, exp_byte(m, a));
    @(negedge clk);
  endtask

  task automatic bit_do(input logic [7:0] a, input logic [1:0] op, input logic v);
    logic [7:0] nb;
    bit_addr = a; bit_op = op; bit_wval = v;
    nb = bit_next(a, op, v);
    write_direct_m(bit_byte_addr(a), nb);
    @(posedge clk); @(negedge clk);
    bit_op = 2'd0;
  endtask

  task automatic bit_check(input logic [7:0] a, input string req);
    logic [7:0] ba;
    bit_addr = a; bit_op = 2'd0;
    ba = bit_byte_addr(a);
    #1;
    check8(req, {7'd0, bit_rdata}, {7'd0, read_direct_m(ba)[a % 8]});
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < 128; i++) sfr_m[i] = 8'h00;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R11: everything reads zero after reset
    for (int i = 0; i < 256; i++) rd_check(2'd1, 8'(i), "R11 ram clear");
    for (int i = 128; i < 256; i++) rd_check(2'd0, 8'(i), "R11 sfr clear");

    // R3: fill all RAM through indirect
    for (int i = 0; i < 256; i++) wr_byte(2'd1, 8'(i), 8'(i * 7 + 3));
    // R2: fill special registers through direct
    for (int i = 128; i < 256; i++) wr_byte(2'd0, 8'(i), 8'(i ^ 8'h33));
    // R1: direct low equals indirect low
    for (int i = 0; i < 128; i++) rd_check(2'd0, 8'(i), "R1 direct low");
    // R3: upper RAM intact and reachable by indirect only
    for (int i = 128; i < 256; i++) rd_check(2'd1, 8'(i), "R3 indirect high");
    // R2: direct high shows special registers
    for (int i = 128; i < 256; i++) rd_check(2'd0, 8'(i), "R2 direct high");
    acc_mode = 2'd0; acc_addr = 8'h90; #1;
    check8("R2 direct 0x90 sfr", acc_rdata, 8'h90 ^ 8'h33);
    @(negedge clk);
    acc_mode = 2'd1; acc_addr = 8'h90; #1;
    check8("R3 indirect 0x90 ram", acc_rdata, 8'(8'h90 * 7 + 3));
    @(negedge clk);

    // R5: accumulator value to watch
    wr_byte(2'd0, 8'hE0, 8'h3C);
    // R4: each bank, each register
    for (int b = 0; b < 4; b++) begin
      wr_byte(2'd0, 8'hD0, 8'(b << 3));
      for (int n = 0; n < 8; n++) rd_check(2'd2, 8'(n), "R4 bank read");
      for (int n = 0; n < 8; n++) wr_byte(2'd2, 8'(8'hF8 | n), 8'(8'hC0 + b * 8 + n));
      for (int n = 0; n < 8; n++) rd_check(2'd1, 8'(b * 8 + n), "R4 bank write");
    end
    acc_mode = 2'd2; acc_addr = 8'h04; #1;
    check8("R4 bank3 R4 is 0x1C", acc_rdata, 8'hDC);
    @(negedge clk);
    acc_mode = 2'd0; acc_addr = 8'hE0; #1;
    check8("R5 accumulator untouched", acc_rdata, 8'h3C);
    @(negedge clk);
    for (int i = 128; i < 256; i++) rd_check(2'd0, 8'(i), "R5 sfr untouched");

    // R6 / R7: read every bit
    for (int a = 0; a < 256; a++) bit_check(8'(a), a < 128 ? "R6 bit read low" : "R7 bit read high");

    // R8: every op on every bit, byte checked after each
    for (int a = 0; a < 256; a++) begin
      bit_do(8'(a), 2'd1, 1'b0);
      rd_check(2'd0, bit_byte_addr(8'(a)), a < 128 ? "R8 set low" : "R8 set high");
      bit_do(8'(a), 2'd2, 1'b1);
      rd_check(2'd0, bit_byte_addr(8'(a)), a < 128 ? "R8 clr low" : "R8 clr high");
      bit_do(8'(a), 2'd3, a[0] ^ a[3]);
      rd_check(2'd0, bit_byte_addr(8'(a)), "R8 put");
      bit_check(8'(a), a < 128 ? "R6 bit after put" : "R7 bit after put");
      bit_do(8'(a), 2'd0, 1'b1);
      rd_check(2'd0, bit_byte_addr(8'(a)), "R8 none");
    end

    // R9: same byte, byte write wins (byte 0x21 bit 0 is bit address 0x08)
    wr_byte(2'd0, 8'h21, 8'h00);
    acc_mode = 2'd0; acc_addr = 8'h21; acc_wdata = 8'hA4; acc_we = 1'b1;
    bit_addr = 8'h08; bit_op = 2'd1;
    @(posedge clk); @(negedge clk);
    acc_we = 1'b0; bit_op = 2'd0; ram_m[8'h21] = 8'hA4;
    rd_check(2'd0, 8'h21, "R9 byte wins ram");
    check8("R9 byte wins value", ram_m[8'h21], 8'hA4);
    // R9: same special register, clear loses to byte write
    acc_mode = 2'd0; acc_addr = 8'hF0; acc_wdata = 8'h08; acc_we = 1'b1;
    bit_addr = 8'hF3; bit_op = 2'd2;
    @(posedge clk); @(negedge clk);
    acc_we = 1'b0; bit_op = 2'd0; sfr_m[7'h70] = 8'h08;
    rd_check(2'd0, 8'hF0, "R9 byte wins sfr");
    // R9: different bytes both land (bit 0x10 is byte 0x22 bit 0)
    wr_byte(2'd0, 8'h22, 8'h00);
    acc_mode = 2'd0; acc_addr = 8'h30; acc_wdata = 8'h5E; acc_we = 1'b1;
    bit_addr = 8'h10; bit_op = 2'd1;
    @(posedge clk); @(negedge clk);
    acc_we = 1'b0; bit_op = 2'd0; ram_m[8'h30] = 8'h5E; ram_m[8'h22] = 8'h01;
    rd_check(2'd0, 8'h30, "R9 both byte");
    rd_check(2'd0, 8'h22, "R9 both bit");

    // R10: old value before the edge, new value after it
    wr_byte(2'd1, 8'h40, 8'h11);
    acc_mode = 2'd1; acc_addr = 8'h40; acc_wdata = 8'h99; acc_we = 1'b1;
    #1;
    check8("R10 before edge", acc_rdata, 8'h11);
    @(posedge clk); #1;
    check8("R10 after edge", acc_rdata, 8'h99);
    @(negedge clk);
    acc_we = 1'b0; ram_m[8'h40] = 8'h99;
    bit_addr = 8'h00; #1;
    check8("R10 bit comb read", {7'd0, bit_rdata}, {7'd0, ram_m[8'h20][0]});
    @(negedge clk);

    // R12: reserved mode
    acc_mode = 2'd3; acc_addr = 8'h45; acc_wdata = 8'hEE; acc_we = 1'b1;
    #1;
    check8("R12 reads zero", acc_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    acc_addr = 8'hC5;
    @(posedge clk); @(negedge clk);
    acc_we = 1'b0;
    rd_check(2'd0, 8'h45, "R12 ram unchanged");
    rd_check(2'd1, 8'hC5, "R12 high ram unchanged");
    rd_check(2'd0, 8'hC5, "R12 sfr unchanged");

    // R11: reset mid-run restores bank 0
    do_reset();
    wr_byte(2'd1, 8'h04, 8'h6A);
    wr_byte(2'd1, 8'h1C, 8'h7B);
    acc_mode = 2'd2; acc_addr = 8'h04; #1;
    check8("R11 bank zero after reset", acc_rdata, 8'h6A);
    @(negedge clk);
    rd_check(2'd0, 8'hD0, "R11 status cleared");
    rd_check(2'd0, 8'h7F, "R11 low cleared");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule